// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Generator

This block generates four independent pulse-width-modulated waveforms from a single input clock. Each channel is programmed with a period length and a low-time length, both counted in input clock cycles and 30 bits wide. Within every period the output is first high for (period − low time) cycles and then low for the remaining low-time cycles. A low time of zero keeps the output high for the whole period. A low time equal to or greater than the period keeps it low.

Software programs the channels through a small 32-bit register bus with a write strobe and a combinational read port. The values that software writes are not used directly by the waveform generator. A channel copies them into private working registers when its start bit rises. While the channel runs, it takes new values only after software writes 1 and then 0 to that channel's update bit. The copy taken at that moment is held back until the current period ends, so a period never mixes old and new settings.

Each channel is controlled by a small state machine with three states. `CH_IDLE` means the channel is stopped and the counter is held at zero. `CH_RUN` means the channel is counting with its working values. `CH_PEND` means the channel is counting and a staged update is waiting for the next period boundary. The transitions are:
- start-rise: `CH_IDLE`→`CH_RUN`, loads the working registers and starts the count at zero.
- stop: `CH_RUN`/`CH_PEND`→`CH_IDLE`, taken when the start bit is 0.
- update-stage: `CH_RUN`→`CH_PEND`, taken on a falling update bit away from a boundary; it captures the staged copy.
- update-direct: `CH_RUN`→`CH_RUN`, taken on a falling update bit exactly at a boundary; it loads the register values at once.
- update-apply: `CH_PEND`→`CH_RUN`, taken at a boundary; it loads the staged copy.
- restage: `CH_PEND`→`CH_PEND`, taken on another falling update bit; it replaces the staged copy.

Top module: `quad_pwm`

## Requirements
- R1: After reset every register reads 0 and all `pwm_out` and `pwm_oe` bits are 0.
- R2: The register layout is as follows. Channel n's low time is at byte address 8·n and its period at 8·n+4, each holding 30 bits; bits 31:30 read as 0. The start register is at 0x44, the update register at 0x4C and the output-enable register at 0xD0, with bit n belonging to channel n. Every register reads back what was last written.
- R3: If the start bit of channel n is written to 1 at clock edge S, `pwm_out[n]` is still 0 after S. From edge S+1 on, it repeats (period − low time) high cycles followed by low-time low cycles.
- R4: While a channel runs, writes to its low-time or period register do not change its output.
- R5: Software writes the update bit to 1 at one edge and to 0 at edge B. The channel captures the register values at edge B+1. The period in progress completes with the old values, and the captured values take effect from the next period boundary.
- R6: If edge B+1 (the falling update) is itself a period boundary, the new values take effect from that boundary.
- R7: A low time of 0 gives a constantly high output while the channel runs.
- R8: A low time equal to or greater than the effective period gives a constantly low output.
- R9: A period value below 2 behaves as a period of 2.
- R10: `pwm_out[n]` is 0 whenever output-enable bit n or start bit n is 0. `pwm_oe[n]` follows output-enable bit n.
- R11: Channels run independently; settings and activity of one channel do not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 4 | Waveform output, one bit per channel |
| pwm_oe | output | 4 | Output-enable, one bit per channel |

## Verification
Two functions of a channel can fall in the same clock cycle. One is the recognition of a falling update bit. The other is the period boundary where the counter wraps. To provoke this, the bench first locks onto a rising output edge, which marks a boundary. It then places the update clear exactly one period later, so that the falling edge is detected at the wrap. The bench judges the result by sampling the output every cycle around that edge. It expects the old high/low pattern up to the boundary and the new pattern in the very next period. A separate scenario clears the update bit in the middle of a period, and there the bench expects the old pattern to finish first.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_PEND = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_LIVE  = 2'd1,
        LD_STAGE = 2'd2
    } ld_src_e;

    localparam int unsigned OFS_START  = 32'h44;
    localparam int unsigned OFS_UPDATE = 32'h4C;
    localparam int unsigned OFS_OE     = 32'hD0;
    localparam int unsigned CH_STRIDE  = 8;
    localparam int unsigned OFS_PERIOD = 4;
    localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned VW  = 30,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic [NCH-1:0][VW-1:0] low_reg,
    output logic [NCH-1:0][VW-1:0] per_reg,
    output logic [NCH-1:0]      start_reg,
    output logic [NCH-1:0]      upd_reg,
    output logic [NCH-1:0]      oe_reg
);

    localparam logic [AW-1:0] A_START = AW'(OFS_START);
    localparam logic [AW-1:0] A_UPD   = AW'(OFS_UPDATE);
    localparam logic [AW-1:0] A_OE    = AW'(OFS_OE);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DW-1:VW];

    genvar n;
    generate
        for (n = 0; n < NCH; n++) begin : g_chreg
            localparam logic [AW-1:0] A_LOW = AW'(n * CH_STRIDE);
            localparam logic [AW-1:0] A_PER = AW'(n * CH_STRIDE + OFS_PERIOD);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_reg[n] <= '0;
                    per_reg[n] <= '0;
                end else if (bus_we) begin
                    if (bus_addr == A_LOW) low_reg[n] <= bus_wdata[VW-1:0];
                    if (bus_addr == A_PER) per_reg[n] <= bus_wdata[VW-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_reg <= '0;
            upd_reg   <= '0;
            oe_reg    <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_START) start_reg <= bus_wdata[NCH-1:0];
            if (bus_addr == A_UPD)   upd_reg   <= bus_wdata[NCH-1:0];
            if (bus_addr == A_OE)    oe_reg    <= bus_wdata[NCH-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'(c * CH_STRIDE))
                bus_rdata = DW'(low_reg[c]);
            if (bus_addr == AW'(c * CH_STRIDE + OFS_PERIOD))
                bus_rdata = DW'(per_reg[c]);
        end
        if (bus_addr == A_START) bus_rdata = DW'(start_reg);
        if (bus_addr == A_UPD)   bus_rdata = DW'(upd_reg);
        if (bus_addr == A_OE)    bus_rdata = DW'(oe_reg);
    end

    AST_UPD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_UPD) |=> (upd_reg == $past(bus_wdata[NCH-1:0]))); // R2

    AST_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OE) |=> (oe_reg == $past(bus_wdata[NCH-1:0]))); // R2

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import pwm_pkg::*;
#(
    parameter int unsigned VW = 30
) (
    input  logic          run,
    input  logic [VW-1:0] cnt,
    input  logic [VW-1:0] per_w,
    input  logic [VW-1:0] low_w,
    output logic [VW-1:0] per_eff,
    output logic          bound,
    output logic          wave
);

    logic [VW-1:0] hi_len;

    always_comb begin
        per_eff = (per_w < VW'(MIN_PERIOD)) ? VW'(MIN_PERIOD) : per_w;
        hi_len  = (low_w >= per_eff) ? '0 : (per_eff - low_w);
        bound   = run && (cnt == (per_eff - VW'(1)));
        wave    = run && (cnt < hi_len);
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int unsigned VW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          upd,
    input  logic          oe,
    input  logic [VW-1:0] per_reg,
    input  logic [VW-1:0] low_reg,
    output logic          out
);

    ch_state_e     state, nxt;
    ld_src_e       ld;
    logic          stage_cap, cnt_clr;
    logic          start_d, upd_d, rise, fall;
    logic [VW-1:0] cnt, per_w, low_w, per_s, low_s, per_eff;
    logic          bound, wave, run;

    assign rise = start && !start_d;
    assign fall = upd_d && !upd;
    assign run  = (state != CH_IDLE);

    pwm_wave #(.VW(VW)) u_wave (
        .run    (run),
        .cnt    (cnt),
        .per_w  (per_w),
        .low_w  (low_w),
        .per_eff(per_eff),
        .bound  (bound),
        .wave   (wave)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        ld        = LD_NONE;
        stage_cap = 1'b0;
        cnt_clr   = 1'b0;
        unique case (state)
            CH_IDLE: begin
                cnt_clr = 1'b1;
                if (rise) begin
                    nxt = CH_RUN;
                    ld  = LD_LIVE;
                end
            end
            CH_RUN: begin
                if (!start) begin
                    nxt     = CH_IDLE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_clr = bound;
                    if (fall && bound) begin
                        ld = LD_LIVE;
                    end else if (fall) begin
                        stage_cap = 1'b1;
                        nxt       = CH_PEND;
                    end
                end
            end
            CH_PEND: begin
                if (!start) begin
                    nxt     = CH_IDLE;
                    cnt_clr = 1'b1;
                end else if (bound) begin
                    cnt_clr = 1'b1;
                    nxt     = CH_RUN;
                    ld      = fall ? LD_LIVE : LD_STAGE;
                end else if (fall) begin
                    stage_cap = 1'b1;
                end
            end
            default: begin
                nxt     = CH_IDLE;
                cnt_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_d <= 1'b0;
            upd_d   <= 1'b0;
            cnt     <= '0;
            per_w   <= '0;
            low_w   <= '0;
            per_s   <= '0;
            low_s   <= '0;
        end else begin
            start_d <= start;
            upd_d   <= upd;
            if (cnt_clr)  cnt <= '0;
            else if (run) cnt <= cnt + VW'(1);
            if (stage_cap) begin
                per_s <= per_reg;
                low_s <= low_reg;
            end
            unique case (ld)
                LD_LIVE: begin
                    per_w <= per_reg;
                    low_w <= low_reg;
                end
                LD_STAGE: begin
                    per_w <= per_s;
                    low_w <= low_s;
                end
                default: ;
            endcase
        end
    end

    assign out = wave && oe && start;

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && rise) |=> (state == CH_RUN && cnt == '0)); // R3

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < per_eff)); // R3

    AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bound) |=> ($stable(per_w) && $stable(low_w))); // R5

    AST_STAGE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && start && fall && !bound) |=> (state == CH_PEND)); // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |=> (state == CH_IDLE)); // R10

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && low_w == '0) |-> wave); // R7

    AST_OVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && low_w >= per_eff) |-> !wave); // R8

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned VW  = 30,
    parameter int unsigned AW  = 8,
    parameter int unsigned DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] pwm_oe
);

    logic [NCH-1:0][VW-1:0] low_reg, per_reg;
    logic [NCH-1:0]         start_reg, upd_reg, oe_reg;

    pwm_regfile #(.NCH(NCH), .VW(VW), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .low_reg  (low_reg),
        .per_reg  (per_reg),
        .start_reg(start_reg),
        .upd_reg  (upd_reg),
        .oe_reg   (oe_reg)
    );

    genvar n;
    generate
        for (n = 0; n < NCH; n++) begin : g_ch
            pwm_channel #(.VW(VW)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .start  (start_reg[n]),
                .upd    (upd_reg[n]),
                .oe     (oe_reg[n]),
                .per_reg(per_reg[n]),
                .low_reg(low_reg[n]),
                .out    (pwm_out[n])
            );
        end
    endgenerate

    assign pwm_oe = oe_reg;

endmodule

// File: tb/quad_pwm_test.sv
`timescale 1ns/1ps
module quad_pwm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out, pwm_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [3:0] start_v = '0, oe_v = '0, upd_v = '0;

    localparam logic [7:0] A_START = 8'h44, A_UPD = 8'h4C, A_OE = 8'hD0;

    always #5 clk = ~clk;

    quad_pwm uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic set_lp(input int ch, input int low, input int per);
        wr(8'(ch * 8), 32'(low));
        wr(8'(ch * 8 + 4), 32'(per));
    endtask

    task automatic sync_rise(input int ch, input string tag);
        int lim = 0;
        while (pwm_out[ch] && lim < 200) begin @(negedge clk); lim++; end
        while (!pwm_out[ch] && lim < 400) begin @(negedge clk); lim++; end
        if (lim >= 400) check(1'b0, tag, 0, 1);
    endtask

    task automatic measure(input int ch, input int hi, input int lo, input string tag);
        int h = 0, l = 0;
        sync_rise(ch, tag);
        while (pwm_out[ch] && h < 100) begin h++; @(negedge clk); end
        while (!pwm_out[ch] && l < 100) begin l++; @(negedge clk); end
        check(h == hi, {tag, " high"}, h, hi);
        check(l == lo, {tag, " low"}, l, lo);
    endtask

    task automatic hold_level(input int ch, input bit lvl, input int cyc, input string tag);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_reset;
        rd_check(8'h00, 0, "R1 low0");
        rd_check(8'h04, 0, "R1 per0");
        rd_check(A_START, 0, "R1 start");
        rd_check(A_OE, 0, "R1 oe");
        check(pwm_out == 0 && pwm_oe == 0, "R1 outputs", {pwm_out, pwm_oe}, 0);
    endtask

    task automatic t_regmap;
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_check(8'h0C, 32'h3FFF_FFFF, "R2 period 30-bit");
        wr(8'h18, 32'd5);
        rd_check(8'h18, 32'd5, "R2 ch3 low");
        rd_check(8'h08, 32'd0, "R2 ch1 low untouched");
        wr(A_OE, 32'hA);
        rd_check(A_OE, 32'hA, "R2 oe");
        check(pwm_oe == 4'hA, "R2 oe pins", pwm_oe, 4'hA);
        wr(A_OE, 32'h0);
        wr(A_UPD, 32'h6);
        rd_check(A_UPD, 32'h6, "R2 update");
        wr(A_UPD, 32'h0);
    endtask

    task automatic t_basic;
        set_lp(0, 2, 6);
        oe_v[0] = 1'b1; wr(A_OE, 32'(oe_v));
        start_v[0] = 1'b1; wr(A_START, 32'(start_v));
        check(pwm_out[0] == 1'b0, "R3 not yet high", pwm_out[0], 0);
        @(negedge clk);
        check(pwm_out[0] == 1'b1, "R3 first high", pwm_out[0], 1);
        measure(0, 4, 2, "R3 6/2");
    endtask

    task automatic t_ignore;
        set_lp(0, 1, 10);
        measure(0, 4, 2, "R4 write ignored a");
        measure(0, 4, 2, "R4 write ignored b");
    endtask

    task automatic t_coincide;
        int bad = 0;
        set_lp(0, 5, 8);
        sync_rise(0, "R6 sync");
        upd_v[0] = 1'b1; wr(A_UPD, 32'(upd_v));
        repeat (3) @(negedge clk);
        upd_v[0] = 1'b0; wr(A_UPD, 32'(upd_v));
        check(pwm_out[0] == 1'b0, "R6 old low before boundary", pwm_out[0], 0);
        for (int i = 6; i <= 14; i++) begin
            bit e;
            @(negedge clk);
            e = (i <= 8) || (i == 14);
            if (pwm_out[0] != e) begin
                bad++;
                $display("FAIL R6 cycle %0d: actual %0d expected %0d", i, pwm_out[0], e);
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
    endtask

    task automatic t_deferred;
        int bad = 0;
        set_lp(0, 1, 4);
        sync_rise(0, "R5 sync");
        upd_v[0] = 1'b1; wr(A_UPD, 32'(upd_v));
        upd_v[0] = 1'b0; wr(A_UPD, 32'(upd_v));
        for (int i = 2; i <= 12; i++) begin
            bit e;
            if (i > 2) @(negedge clk);
            e = (i <= 2) || (i >= 8 && i <= 10) || (i == 12);
            if (pwm_out[0] != e) begin
                bad++;
                $display("FAIL R5 cycle %0d: actual %0d expected %0d", i, pwm_out[0], e);
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
        measure(0, 3, 1, "R5 new 4/1");
    endtask

    task automatic t_levels;
        set_lp(1, 0, 5);
        set_lp(2, 6, 4);
        oe_v[2:1] = 2'b11; wr(A_OE, 32'(oe_v));
        start_v[2:1] = 2'b11; wr(A_START, 32'(start_v));
        @(negedge clk);
        hold_level(1, 1'b1, 20, "R7 low 0 always high");
        hold_level(2, 1'b0, 20, "R8 low over period always low");
        check(pwm_oe[2] == 1'b1, "R8 ch2 enabled", pwm_oe[2], 1);
    endtask

    task automatic t_clamp;
        set_lp(3, 1, 1);
        oe_v[3] = 1'b1; wr(A_OE, 32'(oe_v));
        start_v[3] = 1'b1; wr(A_START, 32'(start_v));
        measure(3, 1, 1, "R9 period 1 as 2");
        check(pwm_out[1] == 1'b1, "R11 ch1 unaffected", pwm_out[1], 1);
        measure(0, 3, 1, "R11 ch0 unaffected");
    endtask

    task automatic t_gate;
        oe_v[0] = 1'b0; wr(A_OE, 32'(oe_v));
        check(pwm_oe[0] == 1'b0, "R10 oe pin low", pwm_oe[0], 0);
        hold_level(0, 1'b0, 20, "R10 oe off gives low");
        oe_v[0] = 1'b1; wr(A_OE, 32'(oe_v));
        measure(0, 3, 1, "R10 oe back on");
        start_v[0] = 1'b0; wr(A_START, 32'(start_v));
        hold_level(0, 1'b0, 20, "R10 stopped gives low");
        check(pwm_oe[0] == 1'b1, "R10 oe pin follows bit", pwm_oe[0], 1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_basic();
        t_ignore();
        t_coincide();
        t_deferred();
        t_levels();
        t_clamp();
        t_gate();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule